// File: doc/BRIEF.md
# RAID Command Word Legality Checker

This block checks a RAID parity command before the command is accepted. The command arrives as a sequence of 64-bit words on a single port. Each word is taken on a clock edge where `word_valid` is high. The first word is the control word. The next word is the P-lane output word, then the Q-lane output word. After these come as many input words as the control word's count field gives.

Each word is checked while it is taken. The checker keeps a running set of the rules that have been broken. Some rules concern the input list as a whole, for example that an enabled lane must have at least one input feeding it. Those rules are settled on the last word. In the cycle after the last word, the block pulses `done` and reports either accept or reject. It also drives an error-cause vector with one bit for each rule that was broken. The checker performs no part of the command and makes no memory access.

Top module: `raidchk_top`

## Requirements
- R1: The number of input words equals the control-word count field, bits 29:24, whatever its value; 0 means no input words. `done` is high for exactly one cycle, the cycle after the edge that takes the last word (the Q output word when the count is 0), and is low at every other time.
- R2: While `done` is high, `accept` is high exactly when no rule was broken and `reject` is high otherwise. Both are low when `done` is low. `err_cause` holds one bit for each broken rule: all of them are reported, not only the first.
- R3: A nonzero value in control-word bits 63:37 sets `err_cause[0]`.
- R4: A count field outside 1..32 sets `err_cause[1]`. A nonzero value in size bits 2:0 of the control word sets `err_cause[2]`.
- R5: If neither lane enable is set (P lane bit 30, Q lane bit 31), `err_cause[3]` is set.
- R6: Compare mode (P bit 35, Q bit 36) sets `err_cause[4]` when that lane is disabled or when that lane's cross-XOR bit is also set (P bit 33, Q bit 34). Either cross-XOR bit set without both lane enables sets `err_cause[5]`.
- R7: An output word with a nonzero value in bits 63:58 or 55:40 sets `err_cause[6]`. An output word with its full-write bit (57) or no-allocate bit (56) set while its own lane is in compare mode sets `err_cause[7]`. The P word is judged against the P compare bit and the Q word against the Q compare bit.
- R8: An input word with a nonzero value in bits 63:57 or 55:50 sets `err_cause[8]`.
- R9: An input word that enables a lane (P bit 48, Q bit 49) while that lane is disabled in the control word sets `err_cause[9]`. An enabled lane that no input word enables sets `err_cause[10]`.
- R10: An input coefficient (bits 47:40) that is zero with Q bit 49 set, or nonzero with Q bit 49 clear, sets `err_cause[11]`.
- R11: An input word with a nonzero value in address bits 2:0 sets `err_cause[12]`.
- R12: Cycles with `word_valid` low are ignored and do not change the result. A new command's control word may follow the previous command's last word on the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| word_valid | input | 1 | Word on `word_data` is taken at this edge |
| word_data | input | 64 | Command word |
| done | output | 1 | One-cycle pulse when a command's verdict is ready |
| accept | output | 1 | Command is legal (valid while `done` is high) |
| reject | output | 1 | Command is illegal (valid while `done` is high) |
| err_cause | output | 13 | One bit for each broken rule, bit numbers as in R3 to R11 |

## Verification
The bound checker checks on every cycle that `done` never lasts two cycles and always follows a taken word. It also checks that the verdict agrees with the error vector and that accept and reject never appear together. Which bit each rule sets, whether every broken rule is recorded, and when the rules that span the whole input list are judged can only be shown by the bench. The bench runs directed corner commands and many randomly mutated commands with gaps between words, and compares each result with its own model of the rules.

// File: rtl/raidchk_pkg.sv
package raidchk_pkg;
    localparam int WORD_W = 64;
    localparam int CNT_W  = 6;
    localparam int NERR   = 13;

    // error-cause bit numbers
    localparam int E_CTRL_RSVD = 0;
    localparam int E_COUNT     = 1;
    localparam int E_SIZE      = 2;
    localparam int E_NO_LANE   = 3;
    localparam int E_CMP       = 4;
    localparam int E_XOR       = 5;
    localparam int E_OUT_RSVD  = 6;
    localparam int E_OUT_HINT  = 7;
    localparam int E_IN_RSVD   = 8;
    localparam int E_EN_NOLANE = 9;
    localparam int E_NO_INPUT  = 10;
    localparam int E_COEF      = 11;
    localparam int E_IN_ALIGN  = 12;

    typedef logic [NERR-1:0] err_t;

    typedef enum logic [1:0] {ST_CTRL, ST_OUTP, ST_OUTQ, ST_IN} st_e;

    typedef struct packed {
        logic             q_cmp;
        logic             p_cmp;
        logic             q_xor;
        logic             p_xor;
        logic             q_on;
        logic             p_on;
        logic [CNT_W-1:0] count;
    } ctrl_t;

    function automatic ctrl_t unpack_ctrl(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c.q_cmp = w[36];
        c.p_cmp = w[35];
        c.q_xor = w[34];
        c.p_xor = w[33];
        c.q_on  = w[31];
        c.p_on  = w[30];
        c.count = w[29:24];
        return c;
    endfunction
endpackage

// File: rtl/raidchk_ctrl_dec.sv
module raidchk_ctrl_dec
    import raidchk_pkg::*;
#(
    parameter int MAX_IN = 32
) (
    input  logic [WORD_W-1:0] w,
    output ctrl_t             c,
    output err_t              err
);
    always_comb begin
        c   = unpack_ctrl(w);
        err = '0;
        err[E_CTRL_RSVD] = |w[63:37];
        err[E_COUNT]     = (c.count == '0) || (32'(c.count) > MAX_IN);
        err[E_SIZE]      = |w[2:0];
        err[E_NO_LANE]   = !(c.p_on || c.q_on);
        err[E_CMP]       = (c.p_cmp && (!c.p_on || c.p_xor)) ||
                           (c.q_cmp && (!c.q_on || c.q_xor));
        err[E_XOR]       = (c.p_xor || c.q_xor) && !(c.p_on && c.q_on);
    end
endmodule

// File: rtl/raidchk_out_chk.sv
module raidchk_out_chk
    import raidchk_pkg::*;
(
    input  logic [WORD_W-1:0] w,
    input  logic              lane_cmp,
    output err_t              err
);
    always_comb begin
        err = '0;
        err[E_OUT_RSVD] = (|w[63:58]) || (|w[55:40]);
        err[E_OUT_HINT] = lane_cmp && (w[57] || w[56]);
    end
endmodule

// File: rtl/raidchk_in_chk.sv
module raidchk_in_chk
    import raidchk_pkg::*;
(
    input  logic [WORD_W-1:0] w,
    input  logic              p_on,
    input  logic              q_on,
    output logic              p_en,
    output logic              q_en,
    output err_t              err
);
    logic [7:0] coef;

    always_comb begin
        p_en = w[48];
        q_en = w[49];
        coef = w[47:40];
        err  = '0;
        err[E_IN_RSVD]   = (|w[63:57]) || (|w[55:50]);
        err[E_EN_NOLANE] = (p_en && !p_on) || (q_en && !q_on);
        err[E_COEF]      = q_en ? (coef == 8'd0) : (coef != 8'd0);
        err[E_IN_ALIGN]  = |w[2:0];
    end
endmodule

// File: rtl/raidchk_top.sv
module raidchk_top
    import raidchk_pkg::*;
#(
    parameter int MAX_IN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              done,
    output logic              accept,
    output logic              reject,
    output logic [NERR-1:0]   err_cause
);
    st_e              st;
    ctrl_t            ctl;
    logic [CNT_W-1:0] rem;
    err_t             acc;
    logic             seen_p, seen_q;
    logic             done_q, ok_q;
    err_t             err_q;

    ctrl_t            dec_c;
    err_t             ctrl_err, out_err, in_err;
    logic             in_p, in_q;

    raidchk_ctrl_dec #(.MAX_IN(MAX_IN)) u_ctrl (
        .w(word_data), .c(dec_c), .err(ctrl_err)
    );

    raidchk_out_chk u_out (
        .w(word_data),
        .lane_cmp((st == ST_OUTP) ? ctl.p_cmp : ctl.q_cmp),
        .err(out_err)
    );

    raidchk_in_chk u_in (
        .w(word_data), .p_on(ctl.p_on), .q_on(ctl.q_on),
        .p_en(in_p), .q_en(in_q), .err(in_err)
    );

    err_t acc_nx, final_err;
    logic seen_p_nx, seen_q_nx, last_word;

    always_comb begin
        acc_nx    = acc;
        seen_p_nx = seen_p;
        seen_q_nx = seen_q;
        unique case (st)
            ST_CTRL: begin
                acc_nx    = ctrl_err;
                seen_p_nx = 1'b0;
                seen_q_nx = 1'b0;
            end
            ST_OUTP, ST_OUTQ: acc_nx = acc | out_err;
            ST_IN: begin
                acc_nx    = acc | in_err;
                seen_p_nx = seen_p | in_p;
                seen_q_nx = seen_q | in_q;
            end
            default: acc_nx = acc;
        endcase
        last_word = word_valid &&
                    (((st == ST_OUTQ) && (rem == '0)) ||
                     ((st == ST_IN) && (rem == CNT_W'(1))));
        final_err = acc_nx;
        final_err[E_NO_INPUT] = (ctl.p_on && !seen_p_nx) ||
                                (ctl.q_on && !seen_q_nx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_CTRL;
            ctl    <= '0;
            rem    <= '0;
            acc    <= '0;
            seen_p <= 1'b0;
            seen_q <= 1'b0;
            done_q <= 1'b0;
            ok_q   <= 1'b0;
            err_q  <= '0;
        end else begin
            done_q <= last_word;
            if (last_word) begin
                err_q <= final_err;
                ok_q  <= (final_err == '0);
            end
            if (word_valid) begin
                acc    <= acc_nx;
                seen_p <= seen_p_nx;
                seen_q <= seen_q_nx;
                unique case (st)
                    ST_CTRL: begin
                        ctl <= dec_c;
                        rem <= dec_c.count;
                        st  <= ST_OUTP;
                    end
                    ST_OUTP: st <= ST_OUTQ;
                    ST_OUTQ: st <= (rem == '0) ? ST_CTRL : ST_IN;
                    ST_IN: begin
                        rem <= rem - CNT_W'(1);
                        if (rem == CNT_W'(1)) st <= ST_CTRL;
                    end
                    default: st <= ST_CTRL;
                endcase
            end
        end
    end

    assign done      = done_q;
    assign accept    = done_q & ok_q;
    assign reject    = done_q & ~ok_q;
    assign err_cause = err_q;
endmodule

// File: rtl/raidchk_sva.sv
module raidchk_sva
    import raidchk_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            word_valid,
    input logic            done,
    input logic            accept,
    input logic            reject,
    input logic [NERR-1:0] err_cause
);
    // R1
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R1
    done_after_word_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(word_valid));

    // R2
    accept_clean_chk: assert property (@(posedge clk) disable iff (rst)
        accept |-> (err_cause == '0));

    // R2
    reject_cause_chk: assert property (@(posedge clk) disable iff (rst)
        reject |-> (err_cause != '0));

    // R2
    verdict_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({accept, reject}));

    // R2
    verdict_gated_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> !(accept || reject));
endmodule

bind raidchk_top raidchk_sva u_sva (
    .clk(clk), .rst(rst), .word_valid(word_valid), .done(done),
    .accept(accept), .reject(reject), .err_cause(err_cause)
);

// File: tb/tb_raidchk_top.sv
module tb_raidchk_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        word_valid = 1'b0;
    logic [63:0] word_data = '0;
    logic        done, accept, reject;
    logic [12:0] err_cause;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    raidchk_top dut (
        .clk(clk), .rst(rst), .word_valid(word_valid), .word_data(word_data),
        .done(done), .accept(accept), .reject(reject), .err_cause(err_cause)
    );

    logic [63:0] cw, pw, qw;
    logic [63:0] iw [0:63];
    bit          gaps = 1'b0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // model of the rules, written from the requirements
    function automatic logic [12:0] model();
        logic [12:0] e = '0;
        int n = int'(cw[29:24]);
        bit po = cw[30], qo = cw[31];
        bit pc = cw[35], qc = cw[36], px = cw[33], qx = cw[34];
        bit sp = 0, sq = 0;
        e[0] = |cw[63:37];
        e[1] = (n == 0) || (n > 32);
        e[2] = |cw[2:0];
        e[3] = !(po || qo);
        e[4] = (pc && (!po || px)) || (qc && (!qo || qx));
        e[5] = (px || qx) && !(po && qo);
        e[6] = (|pw[63:58]) || (|pw[55:40]) || (|qw[63:58]) || (|qw[55:40]);
        e[7] = (pc && (pw[57] || pw[56])) || (qc && (qw[57] || qw[56]));
        for (int k = 0; k < n; k++) begin
            if ((|iw[k][63:57]) || (|iw[k][55:50])) e[8] = 1'b1;
            if ((iw[k][48] && !po) || (iw[k][49] && !qo)) e[9] = 1'b1;
            if (iw[k][49] ? (iw[k][47:40] == 8'd0) : (iw[k][47:40] != 8'd0)) e[11] = 1'b1;
            if (|iw[k][2:0]) e[12] = 1'b1;
            sp |= iw[k][48];
            sq |= iw[k][49];
        end
        e[10] = (po && !sp) || (qo && !sq);
        return e;
    endfunction

    task automatic put(input logic [63:0] w, input bit is_last);
        if (gaps && ($urandom_range(0, 3) == 0)) begin
            word_valid = 1'b0;
            word_data  = {$urandom, $urandom};
            @(negedge clk);
            // R12: an idle cycle must not end the command
            if (!is_last) check("R12 idle", {63'd0, done}, 64'd0);
        end
        word_valid = 1'b1;
        word_data  = w;
        @(negedge clk);
    endtask

    task automatic run_cmd(input string tag);
        logic [12:0] exp = model();
        int n = int'(cw[29:24]);
        put(cw, 1'b0);
        put(pw, 1'b0);
        put(qw, n == 0);
        for (int k = 0; k < n; k++) put(iw[k], k == n - 1);
        word_valid = 1'b0;
        word_data  = '0;
        // the last word was taken at the edge just passed; verdict visible now
        check({"R1 done ", tag}, {63'd0, done}, 64'd1);
        check({"R2 err_cause ", tag}, {51'd0, err_cause}, {51'd0, exp});
        check({"R2 verdict ", tag}, {62'd0, accept, reject},
              {62'd0, (exp == '0), (exp != '0)});
        @(negedge clk);
        check({"R1 pulse ", tag}, {63'd0, done}, 64'd0);
    endtask

    // a legal command with n inputs
    task automatic make_legal(input int n, input bit po, input bit qo);
        cw = '0;
        cw[23:3]  = 21'($urandom_range(1, 4000));
        cw[29:24] = 6'(n);
        cw[30] = po;
        cw[31] = qo;
        cw[32] = 1'($urandom);
        if (po && qo && $urandom_range(0, 1) == 1) begin
            cw[33] = 1'($urandom);
            cw[34] = 1'($urandom);
        end
        if (po && !cw[33]) cw[35] = 1'($urandom);
        if (qo && !cw[34]) cw[36] = 1'($urandom);
        pw = {40'd0, 24'($urandom)};
        qw = {40'd0, 24'($urandom)};
        pw[39:3] = 37'($urandom);
        qw[39:3] = 37'($urandom);
        if (!cw[35]) pw[57:56] = 2'($urandom);
        if (!cw[36]) qw[57:56] = 2'($urandom);
        for (int k = 0; k < 64; k++) begin
            logic pe = po & 1'($urandom);
            logic qe = qo & 1'($urandom);
            if (k == 0) begin pe = po; qe = qo; end
            iw[k] = '0;
            iw[k][39:3] = 37'($urandom);
            iw[k][56]   = 1'($urandom);
            iw[k][48]   = pe;
            iw[k][49]   = qe;
            iw[k][47:40] = qe ? 8'($urandom_range(1, 255)) : 8'd0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R2 reset", {60'd0, done, accept, reject, 1'b0}, 64'd0);
        check("R2 reset err", {51'd0, err_cause}, 64'd0);

        make_legal(1, 1, 1);          run_cmd("legal single");
        make_legal(32, 1, 1);         run_cmd("legal 32");
        make_legal(33, 1, 0);         run_cmd("R4 count 33");
        make_legal(0, 1, 1);          run_cmd("R4 R9 count 0");
        make_legal(3, 0, 0);          run_cmd("R5 no lane");
        make_legal(2, 1, 1); cw[40] = 1'b1; cw[1] = 1'b1; run_cmd("R3 R4 rsvd+size");
        make_legal(2, 1, 0); cw[35] = 1'b0; cw[36] = 1'b1; run_cmd("R6 cmp off lane");
        make_legal(2, 1, 0); cw[34] = 1'b1; run_cmd("R6 xor one lane");
        make_legal(2, 1, 1); cw[33] = 1'b0; cw[35] = 1'b1; pw[57] = 1'b1; run_cmd("R7 hint cmp");
        make_legal(2, 1, 1); qw[45] = 1'b1; run_cmd("R7 out rsvd");
        make_legal(2, 1, 0); iw[1][52] = 1'b1; run_cmd("R8 in rsvd");
        make_legal(2, 1, 0); iw[1][49] = 1'b1; iw[1][47:40] = 8'd7; run_cmd("R9 qen no lane");
        make_legal(2, 1, 1); iw[1][49] = 1'b1; iw[1][47:40] = 8'd0; run_cmd("R10 zero coef");
        make_legal(2, 1, 0); iw[0][47:40] = 8'd3; run_cmd("R10 coef no qen");
        make_legal(2, 1, 1); iw[1][1] = 1'b1; run_cmd("R11 align");
        make_legal(63, 1, 1); run_cmd("R4 count 63");

        gaps = 1'b1;
        for (int t = 0; t < 400; t++) begin
            make_legal($urandom_range(1, 6), 1'($urandom), 1'($urandom));
            if ($urandom_range(0, 2) != 0) begin
                int sel = $urandom_range(0, 3 + int'(cw[29:24]) - 1);
                int b   = $urandom_range(0, 63);
                if (sel == 0) begin
                    if (b < 24 || b > 29) cw[b] = ~cw[b];
                end
                else if (sel == 1) pw[b] = ~pw[b];
                else if (sel == 2) qw[b] = ~qw[b];
                else iw[sel-3][b] = ~iw[sel-3][b];
            end
            run_cmd("R12 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule